// File: doc/BRIEF.md
# Fixed-Priority Interrupt Selector with Illegal-Opcode Trap

This block gathers every interrupt-like event that a small 8-bit CPU core can see and picks one of them. There are four groups of requests. The first is a pulse from the instruction decoder when it meets an undefined opcode. The second is a non-maskable line. The third is a set of external maskable lines, and the last is a set of request lines from on-chip peripherals. When the core signals that it can accept an interrupt, the block issues a single one-cycle acknowledge. That acknowledge carries the identifier of the winning source and the address the core must jump to.

The undefined-opcode trap outranks everything, including the non-maskable line. It jumps to address 0x0000, which is also where execution starts after reset. So that start-up code can tell the two cases apart, the block keeps a trap flag. Reset clears the flag, an acknowledged trap sets it, and software clears it with an explicit write strobe.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, `ack_o`, `req_o` and `trap_flag_o` are all 0.
- R2: A pulse on `trap_req_i` is held until it is acknowledged. It always wins, with identifier 0 and jump address 0x0000.
- R3: `trap_flag_o` rises in the same cycle as the acknowledge of a trap. It then stays 1 until `trap_flag_clr_i` or reset. When a trap acknowledge and a clear strobe arrive in the same cycle, the flag ends up set.
- R4: The non-maskable line reacts to a rising edge only. A level held high yields one request. The request is held until it is acknowledged, and neither the global enable nor the individual enables affect it.
- R5: Identifiers run in priority order, lowest number first: 0 is the trap, 1 is the non-maskable line, 2 to 4 are the external lines 0 to 2, and 5 to 11 are the peripheral lines 0 to 6.
- R6: An external or peripheral line requests only while it is high, its enable bit is 1 and `gie_i` is 1. These lines are not latched, so dropping one removes its request.
- R7: `req_o` goes to 1 one clock after a request becomes active. An acknowledge appears exactly one clock after a cycle in which both `take_i` and `req_o` are 1. Each such cycle gives exactly one acknowledge, and any lower-priority latched request stays pending.
- R8: The jump address is 0x0066 for identifier 1 and 0x0038 for identifier 2. For every identifier n of 3 or more it is 0x0100 + 2*(n-3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req_i | input | 1 | Undefined-opcode pulse from the decoder |
| nmi_i | input | 1 | Non-maskable request, acts on its rising edge |
| ext_irq_i | input | 3 | External maskable lines, level-sensitive |
| per_irq_i | input | 7 | Peripheral request lines, level-sensitive |
| gie_i | input | 1 | Global enable for the maskable lines |
| ext_en_i | input | 3 | Individual enables for the external lines |
| per_en_i | input | 7 | Individual enables for the peripheral lines |
| take_i | input | 1 | Core is ready to accept an interrupt |
| trap_flag_clr_i | input | 1 | Software strobe that clears the trap flag |
| req_o | output | 1 | A request is active |
| ack_o | output | 1 | One-cycle acknowledge |
| ack_id_o | output | 4 | Identifier of the acknowledged source |
| ack_addr_o | output | 16 | Jump address for the acknowledged source |
| trap_flag_o | output | 1 | 1 = the last entry at 0x0000 came from a trap |

## Verification
The hardest case to reach is a trap and a non-maskable edge that are both latched at once. The trap must win, and the non-maskable request must survive to be taken on a later acknowledge. The stimulus reaches this and similar cases with a sweep. It walks all 1024 level patterns of the ten maskable lines under four enable setups. On a fixed schedule it also pulses the trap, toggles the non-maskable line and strobes the flag clear, so latched requests pile up behind one another. A final directed step issues the trap acknowledge and the flag clear in the same cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int ID_TRAP = 0;
    localparam int ID_NMI  = 1;
    localparam int ID_EXT0 = 2;
    localparam logic [15:0] ADDR_TRAP = 16'h0000;
    localparam logic [15:0] ADDR_NMI  = 16'h0066;
    localparam logic [15:0] ADDR_EXT0 = 16'h0038;
endpackage

// File: rtl/irq_latch.sv
module irq_latch #(
    parameter int N_EXT = 3,
    parameter int N_PER = 7,
    localparam int NSRC = 2 + N_EXT + N_PER
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_i,
    input  logic             nmi_i,
    input  logic [N_EXT-1:0] ext_i,
    input  logic [N_PER-1:0] per_i,
    input  logic             gie_i,
    input  logic [N_EXT-1:0] ext_en_i,
    input  logic [N_PER-1:0] per_en_i,
    input  logic             clr_trap_i,
    input  logic             clr_nmi_i,
    output logic [NSRC-1:0]  req_o
);
    typedef struct packed {
        logic             trap_pend;
        logic             nmi_pend;
        logic             nmi_prev;
        logic [N_EXT-1:0] ext_lvl;
        logic [N_PER-1:0] per_lvl;
    } lat_t;

    lat_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.trap_pend = (st_q.trap_pend & ~clr_trap_i) | trap_i;
        st_d.nmi_pend  = (st_q.nmi_pend & ~clr_nmi_i) | (nmi_i & ~st_q.nmi_prev);
        st_d.nmi_prev  = nmi_i;
        st_d.ext_lvl   = ext_i;
        st_d.per_lvl   = per_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        req_o[0] = st_q.trap_pend;
        req_o[1] = st_q.nmi_pend;
        req_o[2 +: N_EXT]     = st_q.ext_lvl & ext_en_i & {N_EXT{gie_i}};
        req_o[2+N_EXT +: N_PER] = st_q.per_lvl & per_en_i & {N_PER{gie_i}};
    end

    // R4: a level that was already high cannot raise a new request
    a_r4_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.nmi_pend && st_q.nmi_prev) |=> !st_q.nmi_pend);
    // R4: a pending request survives until cleared
    a_r4_nmi_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.nmi_pend && !clr_nmi_i) |=> st_q.nmi_pend);
    // R2: trap pending survives until cleared
    a_r2_trap_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.trap_pend && !clr_trap_i) |=> st_q.trap_pend);
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int N = 12,
    localparam int ID_W = $clog2(N)
) (
    input  logic [N-1:0]    req_i,
    output logic            any_o,
    output logic [ID_W-1:0] win_o
);
    always_comb begin
        win_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) win_o = ID_W'(i);
        end
        any_o = |req_i;
    end
endmodule

// File: rtl/irq_trapflag.sv
module irq_trapflag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R3: clear strobe without a set leaves the flag low
    a_r3_clear_wins_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_o);
    // R3: flag holds without a clear strobe
    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
    parameter int          N_EXT    = 3,
    parameter int          N_PER    = 7,
    parameter logic [15:0] TBL_BASE = 16'h0100,
    localparam int NSRC = 2 + N_EXT + N_PER,
    localparam int ID_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_req_i,
    input  logic             nmi_i,
    input  logic [N_EXT-1:0] ext_irq_i,
    input  logic [N_PER-1:0] per_irq_i,
    input  logic             gie_i,
    input  logic [N_EXT-1:0] ext_en_i,
    input  logic [N_PER-1:0] per_en_i,
    input  logic             take_i,
    input  logic             trap_flag_clr_i,
    output logic             req_o,
    output logic             ack_o,
    output logic [ID_W-1:0]  ack_id_o,
    output logic [15:0]      ack_addr_o,
    output logic             trap_flag_o
);
    import irq_pkg::*;

    typedef struct packed {
        logic            ack;
        logic [ID_W-1:0] id;
        logic [15:0]     addr;
    } ack_t;

    ack_t            ack_d, ack_q;
    logic [NSRC-1:0] req_vec;
    logic            any_req;
    logic [ID_W-1:0] win;
    logic            grant;
    logic            clr_trap, clr_nmi;

    irq_latch #(.N_EXT(N_EXT), .N_PER(N_PER)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .trap_i     (trap_req_i),
        .nmi_i      (nmi_i),
        .ext_i      (ext_irq_i),
        .per_i      (per_irq_i),
        .gie_i      (gie_i),
        .ext_en_i   (ext_en_i),
        .per_en_i   (per_en_i),
        .clr_trap_i (clr_trap),
        .clr_nmi_i  (clr_nmi),
        .req_o      (req_vec)
    );

    irq_prio #(.N(NSRC)) u_prio (
        .req_i (req_vec),
        .any_o (any_req),
        .win_o (win)
    );

    irq_trapflag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (clr_trap),
        .clr_i  (trap_flag_clr_i),
        .flag_o (trap_flag_o)
    );

    function automatic logic [15:0] entry_addr(input logic [ID_W-1:0] id);
        if (int'(id) == ID_TRAP)      return ADDR_TRAP;
        else if (int'(id) == ID_NMI)  return ADDR_NMI;
        else if (int'(id) == ID_EXT0) return ADDR_EXT0;
        else return TBL_BASE + 16'((int'(id) - 3) * 2);
    endfunction

    always_comb begin
        grant    = take_i & any_req;
        clr_trap = grant && (int'(win) == ID_TRAP);
        clr_nmi  = grant && (int'(win) == ID_NMI);
        ack_d      = ack_q;
        ack_d.ack  = grant;
        if (grant) begin
            ack_d.id   = win;
            ack_d.addr = entry_addr(win);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ack_q <= '0;
        else        ack_q <= ack_d;
    end

    assign req_o      = any_req;
    assign ack_o      = ack_q.ack;
    assign ack_id_o   = ack_q.id;
    assign ack_addr_o = ack_q.addr;

    // R7: no acknowledge without a preceding take while requesting
    a_r7_ack_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ($past(take_i) && $past(req_o)));
    // R7: a take with a request always yields an acknowledge
    a_r7_take_gives_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && req_o) |=> ack_o);
    // R2: trap acknowledge jumps to zero
    a_r2_trap_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && ack_id_o == '0) |-> (ack_addr_o == 16'h0000));
    // R3: trap acknowledge is accompanied by the flag
    a_r3_flag_on_trap_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && ack_id_o == '0) |-> trap_flag_o);
    // R8: non-maskable entry address
    a_r8_nmi_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && int'(ack_id_o) == 1) |-> (ack_addr_o == 16'h0066));
endmodule

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req_i = 1'b0, nmi_i = 1'b0, gie_i = 1'b0;
    logic [2:0]  ext_irq_i = '0, ext_en_i = '0;
    logic [6:0]  per_irq_i = '0, per_en_i = '0;
    logic        take_i = 1'b0, trap_flag_clr_i = 1'b0;
    logic        req_o, ack_o, trap_flag_o;
    logic [3:0]  ack_id_o;
    logic [15:0] ack_addr_o;

    int n_chk = 0, n_fail = 0;
    logic m_trap = 0, m_nmi = 0, m_prev = 0, m_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .trap_req_i(trap_req_i), .nmi_i(nmi_i),
        .ext_irq_i(ext_irq_i), .per_irq_i(per_irq_i), .gie_i(gie_i),
        .ext_en_i(ext_en_i), .per_en_i(per_en_i), .take_i(take_i),
        .trap_flag_clr_i(trap_flag_clr_i), .req_o(req_o), .ack_o(ack_o),
        .ack_id_o(ack_id_o), .ack_addr_o(ack_addr_o), .trap_flag_o(trap_flag_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_addr(input int id);
        if (id == 0) return 0;
        if (id == 1) return 16'h0066;
        if (id == 2) return 16'h0038;
        return 16'h0100 + 2 * (id - 3);
    endfunction

    function automatic logic [11:0] model_req();
        logic [11:0] r;
        r[0] = m_trap;
        r[1] = m_nmi;
        r[4:2]  = ext_irq_i & ext_en_i & {3{gie_i}};
        r[11:5] = per_irq_i & per_en_i & {7{gie_i}};
        return r;
    endfunction

    initial begin
        #(CLK_PERIOD * 40000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [11:0] r;
        int win;
        step();
        step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 ack", ack_o, 0);
        chk("R1 req", req_o, 0);
        chk("R1 flag", trap_flag_o, 0);

        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int v = 0; v < 1024; v++) begin
                logic [9:0] lv, en;
                int k;
                k = cfg * 1024 + v;
                lv = 10'(v);
                case (cfg)
                    0: begin en = 10'h3FF; gie_i = 1'b1; end
                    1: begin en = 10'h3FF; gie_i = 1'b0; end
                    2: begin en = 10'h2AA; gie_i = 1'b1; end
                    default: begin en = 10'h155; gie_i = 1'b1; end
                endcase
                ext_irq_i = lv[2:0];
                per_irq_i = lv[9:3];
                ext_en_i  = en[2:0];
                per_en_i  = en[9:3];
                trap_req_i = (k % 13 == 0);
                nmi_i = (k % 7 < 3);
                trap_flag_clr_i = (k % 29 == 0);
                step();
                if (trap_req_i) m_trap = 1;
                if (nmi_i && !m_prev) m_nmi = 1; // R4 edge only
                m_prev = nmi_i;
                if (trap_flag_clr_i) m_flag = 0;
                trap_req_i = 1'b0;
                trap_flag_clr_i = 1'b0;
                r = model_req();
                chk("R7 req/R6 gating", req_o, int'(|r));
                chk("R3 flag hold", trap_flag_o, m_flag);
                take_i = 1'b1;
                step();
                take_i = 1'b0;
                chk("R7 ack", ack_o, int'(|r));
                if (|r) begin
                    win = 0;
                    for (int i = 11; i >= 0; i--) if (r[i]) win = i;
                    chk("R5 winner", ack_id_o, win);       // R5 R2 R4 R6
                    chk("R8 addr", ack_addr_o, exp_addr(win));
                    if (win == 0) begin m_trap = 0; m_flag = 1; end
                    if (win == 1) m_nmi = 0;
                    chk("R3 flag after ack", trap_flag_o, m_flag);
                end
            end
        end

        // R3 set wins over simultaneous clear
        ext_irq_i = '0; per_irq_i = '0; nmi_i = 1'b0;
        while (req_o) begin take_i = 1'b1; step(); take_i = 1'b0; end
        trap_flag_clr_i = 1'b1;
        step();
        trap_flag_clr_i = 1'b0;
        chk("R3 cleared", trap_flag_o, 0);
        trap_req_i = 1'b1;
        step();
        trap_req_i = 1'b0;
        chk("R2 trap req", req_o, 1);
        take_i = 1'b1;
        trap_flag_clr_i = 1'b1;
        step();
        take_i = 1'b0;
        trap_flag_clr_i = 1'b0;
        chk("R2 trap id", ack_id_o, 0);
        chk("R3 set beats clear", trap_flag_o, 1);
        step();
        chk("R7 single pulse", ack_o, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule